// File: doc/BRIEF.md
# Coherent cache line state controller

This block keeps the coherency state of a small set of cache lines on the master side of a coherent interconnect. Each line holds four independent flags: valid, unique (clear means shared), owner (clear means lodger) and dirty (clear means clean). When valid is clear, the other three flags carry no meaning. A local requester presents a load, a store or a free for one line. The block answers hits on the spot. It sends the needed command on the read channel, or the needed notice on the write channel, and then applies the read response to the line flags.

A probe from the interconnect can invalidate a line or demote it to shared. If such a probe lands on a line whose shared-to-unique upgrade is still outstanding, the upgrade becomes weak. Its success response then leaves the line as the probe left it, so the store has to be retried.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads 4'b0000 on `flags_o`, where each line occupies bits [4i+3:4i] packed as {valid, unique, owner, dirty}, and neither command channel is valid.
- R2: A load (op 0) to an invalid line issues read op 0 (shared read). A data response (kind 2) sets the line to valid, with unique, owner and dirty taken from `rd_rsp_flags` = {unique, owner, dirty}.
- R3: A store (op 1) to an invalid line issues read op 1 (unique read). The data response leaves the line valid, unique and owner, with dirty taken from the response.
- R4: A store to a valid shared line issues read op 2 (upgrade). A success response (kind 0) then makes the line valid, unique and owner, and keeps its dirty flag.
- R5: A probe that arrives while an upgrade is outstanding on the same line makes that upgrade weak. The upgrade's success response then leaves the flags as the probe set them.
- R6: A load to a valid line, or a store to a valid unique line, issues no command. A store hit sets dirty, and a load hit changes nothing.
- R7: A free (op 2) of a valid dirty owner line issues write op 0 (write-back invalidate) and clears the line to 4'b0000.
- R8: A free of any other valid line issues write op 1 (evict) and clears the line. A free of an invalid line issues nothing.
- R9: An error response (kind 1) leaves the line at 4'b0000 and pulses `err_valid` for one cycle with `err_idx` equal to the line, one cycle after the response.
- R10: A line with a read command outstanding stalls any new request to it (`req_ready` low). A command that is not accepted holds its valid, index and op until `*_cmd_ready` is high.
- R11: A probe of kind 0 clears the line to 4'b0000. A probe of kind 1 clears only the unique flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request accepted this cycle |
| req_idx | input | IDX_W | Line index of the request |
| req_op | input | 2 | 0 load, 1 store, 2 free, 3 ignored |
| rd_cmd_valid | output | 1 | Read-channel command valid |
| rd_cmd_ready | input | 1 | Read-channel command taken |
| rd_cmd_idx | output | IDX_W | Line of the read command |
| rd_cmd_op | output | 2 | 0 shared read, 1 unique read, 2 upgrade |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_idx | input | IDX_W | Line of the response |
| rd_rsp_kind | input | 2 | 0 success, 1 error, 2 data |
| rd_rsp_flags | input | 3 | {unique, owner, dirty} carried with data |
| wr_cmd_valid | output | 1 | Write-channel command valid |
| wr_cmd_ready | input | 1 | Write-channel command taken |
| wr_cmd_idx | output | IDX_W | Line of the write command |
| wr_cmd_op | output | 1 | 0 write-back invalidate, 1 evict |
| prb_valid | input | 1 | Probe present |
| prb_idx | input | IDX_W | Probed line |
| prb_kind | input | 1 | 0 invalidate, 1 make shared |
| err_valid | output | 1 | Read error pulse to the requester |
| err_idx | output | IDX_W | Line that took the error |
| flags_o | output | 4*LINES | Packed flags of every line |

## Verification
The assertions check the handshake rules on every cycle. A stalled command must stay stable. An outstanding command implies its line is busy, and a busy line refuses requests. They also check the error path, where an error response is followed by the error pulse and a cleared line, and no pulse appears without a response. The choice of command for each flag combination, the flag values taken from data and success responses, and the weak-upgrade outcome after a probe can only be shown by the bench's request sequences.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef struct packed {
    logic vld;
    logic uniq;
    logic own;
    logic dty;
  } line_flags_t;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_FREE  = 2'd2;

  localparam logic [1:0] RD_SHARED  = 2'd0;
  localparam logic [1:0] RD_UNIQUE  = 2'd1;
  localparam logic [1:0] RD_UPGRADE = 2'd2;

  localparam logic WR_WBINV = 1'b0;
  localparam logic WR_EVICT = 1'b1;

  localparam logic [1:0] RSP_OK   = 2'd0;
  localparam logic [1:0] RSP_ERR  = 2'd1;
  localparam logic [1:0] RSP_DATA = 2'd2;

  localparam logic PRB_INV = 1'b0;
  localparam logic PRB_SHR = 1'b1;
endpackage

// File: rtl/coh_req_decode.sv
module coh_req_decode
  import coh_pkg::*;
(
  input  logic [1:0]  op,
  input  line_flags_t cur,
  output logic        rd_go,
  output logic [1:0]  rd_op,
  output logic        wr_go,
  output logic        wr_op,
  output logic        upd_en,
  output line_flags_t upd_flags
);
  always_comb begin
    rd_go     = 1'b0;
    rd_op     = RD_SHARED;
    wr_go     = 1'b0;
    wr_op     = WR_EVICT;
    upd_en    = 1'b0;
    upd_flags = cur;
    unique case (op)
      OP_LOAD: begin
        if (!cur.vld) begin
          rd_go = 1'b1;
          rd_op = RD_SHARED;
        end
      end
      OP_STORE: begin
        if (!cur.vld) begin
          rd_go = 1'b1;
          rd_op = RD_UNIQUE;
        end else if (!cur.uniq) begin
          rd_go = 1'b1;
          rd_op = RD_UPGRADE;
        end else begin
          upd_en        = 1'b1;
          upd_flags.dty = 1'b1;
        end
      end
      OP_FREE: begin
        if (cur.vld) begin
          wr_go     = 1'b1;
          wr_op     = (cur.own && cur.dty) ? WR_WBINV : WR_EVICT;
          upd_en    = 1'b1;
          upd_flags = '0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_line_bank.sv
module coh_line_bank
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic [IDX_W-1:0]        acc_idx,
  input  logic                    acc_rd_go,
  input  logic [1:0]              acc_rd_op,
  input  logic                    acc_upd_en,
  input  line_flags_t             acc_upd_flags,
  input  logic                    rsp_valid,
  input  logic [IDX_W-1:0]        rsp_idx,
  input  logic [1:0]              rsp_kind,
  input  logic [2:0]              rsp_flags,
  input  logic                    prb_valid,
  input  logic [IDX_W-1:0]        prb_idx,
  input  logic                    prb_kind,
  output line_flags_t [LINES-1:0] flags,
  output logic [LINES-1:0]        busy
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_flags_t f_q, f_n;
    logic        busy_q, busy_n;
    logic [1:0]  pend_q, pend_n;
    logic        weak_q, weak_n;
    logic        hit_acc, hit_rsp, hit_prb;

    assign hit_acc = acc && (acc_idx == IDX_W'(i));
    assign hit_rsp = rsp_valid && busy_q && (rsp_idx == IDX_W'(i));
    assign hit_prb = prb_valid && (prb_idx == IDX_W'(i));

    always_comb begin
      f_n    = f_q;
      busy_n = busy_q;
      pend_n = pend_q;
      weak_n = weak_q;
      if (hit_prb) begin
        if (prb_kind == PRB_INV) f_n = '0;
        else                     f_n.uniq = 1'b0;
        if (busy_q && pend_q == RD_UPGRADE) weak_n = 1'b1;
      end
      if (hit_acc) begin
        if (acc_rd_go) begin
          busy_n = 1'b1;
          pend_n = acc_rd_op;
          weak_n = 1'b0;
        end
        if (acc_upd_en) f_n = acc_upd_flags;
      end
      if (hit_rsp) begin
        busy_n = 1'b0;
        unique case (rsp_kind)
          RSP_ERR:  f_n = '0;
          RSP_DATA: begin
            f_n.vld  = 1'b1;
            f_n.uniq = rsp_flags[2] || (pend_q == RD_UNIQUE);
            f_n.own  = rsp_flags[1] || (pend_q == RD_UNIQUE);
            f_n.dty  = rsp_flags[0];
          end
          RSP_OK: begin
            if (pend_q == RD_UPGRADE && !weak_n) begin
              f_n.vld  = 1'b1;
              f_n.uniq = 1'b1;
              f_n.own  = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q    <= '0;
        busy_q <= 1'b0;
        pend_q <= RD_SHARED;
        weak_q <= 1'b0;
      end else begin
        f_q    <= f_n;
        busy_q <= busy_n;
        pend_q <= pend_n;
        weak_q <= weak_n;
      end
    end

    assign flags[i] = f_q;
    assign busy[i]  = busy_q;
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [1:0]         req_op,
  output logic               rd_cmd_valid,
  input  logic               rd_cmd_ready,
  output logic [IDX_W-1:0]   rd_cmd_idx,
  output logic [1:0]         rd_cmd_op,
  input  logic               rd_rsp_valid,
  input  logic [IDX_W-1:0]   rd_rsp_idx,
  input  logic [1:0]         rd_rsp_kind,
  input  logic [2:0]         rd_rsp_flags,
  output logic               wr_cmd_valid,
  input  logic               wr_cmd_ready,
  output logic [IDX_W-1:0]   wr_cmd_idx,
  output logic               wr_cmd_op,
  input  logic               prb_valid,
  input  logic [IDX_W-1:0]   prb_idx,
  input  logic               prb_kind,
  output logic               err_valid,
  output logic [IDX_W-1:0]   err_idx,
  output logic [4*LINES-1:0] flags_o
);
  line_flags_t [LINES-1:0] flags_arr;
  logic [LINES-1:0]        busy_vec;
  logic                    req_fire;
  logic                    dec_rd_go, dec_wr_go, dec_wr_op, dec_upd_en;
  logic [1:0]              dec_rd_op;
  line_flags_t             dec_upd_flags;

  logic             rdv_q, rdv_n, wrv_q, wrv_n, wro_q, wro_n, errv_q, errv_n;
  logic [IDX_W-1:0] rdi_q, rdi_n, wri_q, wri_n, erri_q, erri_n;
  logic [1:0]       rdo_q, rdo_n;

  assign req_ready = !busy_vec[req_idx] && !rdv_q && !wrv_q;
  assign req_fire  = req_valid && req_ready;

  coh_req_decode u_dec (
    .op        (req_op),
    .cur       (flags_arr[req_idx]),
    .rd_go     (dec_rd_go),
    .rd_op     (dec_rd_op),
    .wr_go     (dec_wr_go),
    .wr_op     (dec_wr_op),
    .upd_en    (dec_upd_en),
    .upd_flags (dec_upd_flags)
  );

  coh_line_bank #(.LINES(LINES)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc           (req_fire),
    .acc_idx       (req_idx),
    .acc_rd_go     (dec_rd_go),
    .acc_rd_op     (dec_rd_op),
    .acc_upd_en    (dec_upd_en),
    .acc_upd_flags (dec_upd_flags),
    .rsp_valid     (rd_rsp_valid),
    .rsp_idx       (rd_rsp_idx),
    .rsp_kind      (rd_rsp_kind),
    .rsp_flags     (rd_rsp_flags),
    .prb_valid     (prb_valid),
    .prb_idx       (prb_idx),
    .prb_kind      (prb_kind),
    .flags         (flags_arr),
    .busy          (busy_vec)
  );

  always_comb begin
    rdv_n = rdv_q;  rdi_n = rdi_q;  rdo_n = rdo_q;
    wrv_n = wrv_q;  wri_n = wri_q;  wro_n = wro_q;
    if (rdv_q && rd_cmd_ready) rdv_n = 1'b0;
    if (wrv_q && wr_cmd_ready) wrv_n = 1'b0;
    if (req_fire && dec_rd_go) begin
      rdv_n = 1'b1;  rdi_n = req_idx;  rdo_n = dec_rd_op;
    end
    if (req_fire && dec_wr_go) begin
      wrv_n = 1'b1;  wri_n = req_idx;  wro_n = dec_wr_op;
    end
    errv_n = rd_rsp_valid && busy_vec[rd_rsp_idx] && (rd_rsp_kind == RSP_ERR);
    erri_n = errv_n ? rd_rsp_idx : erri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q  <= 1'b0;  rdi_q <= '0;  rdo_q <= RD_SHARED;
      wrv_q  <= 1'b0;  wri_q <= '0;  wro_q <= WR_WBINV;
      errv_q <= 1'b0;  erri_q <= '0;
    end else begin
      rdv_q  <= rdv_n;  rdi_q <= rdi_n;  rdo_q <= rdo_n;
      wrv_q  <= wrv_n;  wri_q <= wri_n;  wro_q <= wro_n;
      errv_q <= errv_n; erri_q <= erri_n;
    end
  end

  assign rd_cmd_valid = rdv_q;
  assign rd_cmd_idx   = rdi_q;
  assign rd_cmd_op    = rdo_q;
  assign wr_cmd_valid = wrv_q;
  assign wr_cmd_idx   = wri_q;
  assign wr_cmd_op    = wro_q;
  assign err_valid    = errv_q;
  assign err_idx      = erri_q;
  assign flags_o      = flags_arr;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [IDX_W-1:0]   req_idx,
  input logic               rd_cmd_valid,
  input logic               rd_cmd_ready,
  input logic [IDX_W-1:0]   rd_cmd_idx,
  input logic [1:0]         rd_cmd_op,
  input logic               wr_cmd_valid,
  input logic               wr_cmd_ready,
  input logic [IDX_W-1:0]   wr_cmd_idx,
  input logic               wr_cmd_op,
  input logic               rd_rsp_valid,
  input logic [IDX_W-1:0]   rd_rsp_idx,
  input logic [1:0]         rd_rsp_kind,
  input logic               err_valid,
  input logic [IDX_W-1:0]   err_idx,
  input logic [4*LINES-1:0] flags_o,
  input logic [LINES-1:0]   busy_vec
);
  logic [3:0] fl [LINES];
  always_comb
    for (int i = 0; i < LINES; i++) fl[i] = flags_o[4*i +: 4];

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid && !rd_cmd_ready |=> rd_cmd_valid && $stable(rd_cmd_idx) && $stable(rd_cmd_op));

  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid && !wr_cmd_ready |=> wr_cmd_valid && $stable(wr_cmd_idx) && $stable(wr_cmd_op));

  a_r10_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> busy_vec[rd_cmd_idx]);

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy_vec[req_idx] |-> !req_ready);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && busy_vec[rd_rsp_idx] && rd_rsp_kind == 2'd1
    |=> err_valid && err_idx == $past(rd_rsp_idx) && fl[$past(rd_rsp_idx)] == 4'b0000);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rsp_valid |=> !err_valid);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_idx(req_idx), .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
  .rd_cmd_idx(rd_cmd_idx), .rd_cmd_op(rd_cmd_op), .wr_cmd_valid(wr_cmd_valid),
  .wr_cmd_ready(wr_cmd_ready), .wr_cmd_idx(wr_cmd_idx), .wr_cmd_op(wr_cmd_op),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_idx(rd_rsp_idx), .rd_rsp_kind(rd_rsp_kind),
  .err_valid(err_valid), .err_idx(err_idx), .flags_o(flags_o), .busy_vec(busy_vec)
);

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  localparam int LINES = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic             req_valid = 0, req_ready;
  logic [IDX_W-1:0] req_idx = 0;
  logic [1:0]       req_op = 0;
  logic             rd_cmd_valid, rd_cmd_ready = 1;
  logic [IDX_W-1:0] rd_cmd_idx;
  logic [1:0]       rd_cmd_op;
  logic             rd_rsp_valid = 0;
  logic [IDX_W-1:0] rd_rsp_idx = 0;
  logic [1:0]       rd_rsp_kind = 0;
  logic [2:0]       rd_rsp_flags = 0;
  logic             wr_cmd_valid, wr_cmd_ready = 1;
  logic [IDX_W-1:0] wr_cmd_idx;
  logic             wr_cmd_op;
  logic             prb_valid = 0;
  logic [IDX_W-1:0] prb_idx = 0;
  logic             prb_kind = 0;
  logic             err_valid;
  logic [IDX_W-1:0] err_idx;
  logic [4*LINES-1:0] flags_o;

  coh_line_ctrl #(.LINES(LINES)) i_coh_line_ctrl (.*);

  int checks = 0, failures = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int line(input int i);
    return int'(flags_o[4*i +: 4]);
  endfunction

  // {op[2], idx[2], rd_go, rd_op[2], wr_go, wr_op, kind[2] (3=none), rflags[3], exp_flags[4]}
  localparam logic [17:0] TBL [10] = '{
    {2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 3'b000, 4'h8}, // R2 load miss
    {2'd1, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 3'b000, 4'hE}, // R4 upgrade
    {2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 3'b000, 4'hF}, // R6 store hit
    {2'd2, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 3'b000, 4'h0}, // R7 write-back
    {2'd1, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 3'b000, 4'hE}, // R3 store miss
    {2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 3'b000, 4'hE}, // R6 load hit
    {2'd2, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3, 3'b000, 4'h0}, // R8 evict clean owner
    {2'd0, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 3'b110, 4'hE}, // R2 flags from data
    {2'd0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 3'b111, 4'h0}, // R9 error
    {2'd2, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 3'b000, 4'h0}  // R8 free invalid
  };

  task automatic send_req(input logic [1:0] op, input int idx);
    @(negedge clk);
    req_valid = 1; req_op = op; req_idx = IDX_W'(idx);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_rsp(input int idx, input logic [1:0] kind, input logic [2:0] fl);
    rd_rsp_valid = 1; rd_rsp_idx = IDX_W'(idx); rd_rsp_kind = kind; rd_rsp_flags = fl;
    @(negedge clk);
    rd_rsp_valid = 0;
  endtask

  task automatic send_prb(input int idx, input logic kind);
    @(negedge clk);
    prb_valid = 1; prb_idx = IDX_W'(idx); prb_kind = kind;
    @(negedge clk);
    prb_valid = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk("R1 flags after reset", int'(flags_o), 0);
    chk("R1 rd cmd idle", int'(rd_cmd_valid), 0);
    chk("R1 wr cmd idle", int'(wr_cmd_valid), 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      logic [17:0] e;
      int idx;
      e = TBL[k];
      idx = int'(e[15:14]);
      send_req(e[17:16], idx);
      chk($sformatf("R2-row%0d rd go", k), int'(rd_cmd_valid), int'(e[13]));
      if (e[13]) begin
        chk($sformatf("R3 row%0d rd op", k), int'(rd_cmd_op), int'(e[12:11]));
        chk($sformatf("R10 row%0d rd idx", k), int'(rd_cmd_idx), idx);
      end
      chk($sformatf("R8 row%0d wr go", k), int'(wr_cmd_valid), int'(e[10]));
      if (e[10]) chk($sformatf("R7 row%0d wr op", k), int'(wr_cmd_op), int'(e[9]));
      @(negedge clk);
      if (e[8:7] != 2'd3) begin
        send_rsp(idx, e[8:7], e[6:4]);
        if (e[8:7] == 2'd1) begin
          chk("R9 err pulse", int'(err_valid), 1);
          chk("R9 err idx", int'(err_idx), idx);
        end
      end
      chk($sformatf("R4 row%0d flags", k), line(idx), int'(e[3:0]));
      @(negedge clk);
      chk($sformatf("R9 row%0d err low", k), int'(err_valid), 0);
    end

    // R10: command stalls while not accepted; busy line stalls requests
    rd_cmd_ready = 0;
    send_req(2'd0, 3);
    repeat (3) @(negedge clk);
    chk("R10 rd held valid", int'(rd_cmd_valid), 1);
    chk("R10 rd held idx", int'(rd_cmd_idx), 3);
    rd_cmd_ready = 1;
    @(negedge clk);
    chk("R10 rd dropped", int'(rd_cmd_valid), 0);
    req_idx = 2'd3; req_op = 2'd0;
    #0.1ns;
    chk("R10 busy line stalls", int'(req_ready), 0);
    send_rsp(3, 2'd2, 3'b011);
    chk("R2 line3 flags", line(3), 4'hB);

    // R11: probes on line 2 (1110)
    send_prb(2, 1'b1);
    chk("R11 make shared", line(2), 4'hA);
    send_prb(2, 1'b0);
    chk("R11 invalidate", line(2), 0);

    // R5: weak upgrade after make-shared probe
    send_req(2'd0, 1);
    @(negedge clk);
    send_rsp(1, 2'd2, 3'b000);
    send_req(2'd1, 1);
    chk("R4 upgrade issued", int'(rd_cmd_op), 2);
    @(negedge clk);
    send_prb(1, 1'b1);
    send_rsp(1, 2'd0, 3'b000);
    chk("R5 weak upgrade keeps shared", line(1), 4'h8);

    // R5: weak upgrade after invalidate probe
    send_req(2'd1, 1);
    @(negedge clk);
    send_prb(1, 1'b0);
    send_rsp(1, 2'd0, 3'b000);
    chk("R5 weak upgrade keeps invalid", line(1), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule